// File: doc/BRIEF.md
# Graphics Write Masking Unit

This unit sits between the command decoder and the memory array of a 32-bit graphics DRAM. Once per clock it turns one command into the write controls for a group of eight adjacent columns. Each column lane carries three things: a column write enable, a 32-bit bit-enable word and a 32-bit data word. The unit also produces the per-byte output enables for reads. It has no knowledge of array timing. It only decides which bits of which columns get written, and with what data.

The unit merges three masking sources. The first is a four-bit byte mask that comes with each command. The second is a per-bit mask register that stays loaded between writes. The third is a block-write path: in one cycle it fills any subset of an aligned group of eight columns with the contents of a colour register. A special-function flag selects between graphics behaviour and plain DRAM behaviour. When the flag is low, the mask register and the block path have no effect. Both registers are loaded from the write-data bus, each by its own strobe. All outputs are registered, so they appear one clock after the command is sampled.

Top module: `gfx_wmask_unit`

## Requirements
- R1: After reset, all outputs are zero, the per-bit mask register holds all ones and the colour register holds zero.
- R2: Byte-mask bit k (k = 0..3) set to 1 clears bit-enable bits 8k+7 down to 8k in every lane, whatever the command.
- R3: A write command (cmd = 2'b10) with the flag low enables exactly one lane, lane col_addr[2:0]. In that lane, data equals wdata and the bit enable equals the byte-mask expansion alone. col_base equals col_addr with bits 2:0 cleared.
- R4: A block command (cmd = 2'b11) with the flag low behaves exactly like a write command with the flag low.
- R5: A write command with the flag high ANDs the byte-mask expansion with the per-bit mask register to form the bit enable.
- R6: A block command with the flag high enables lane i exactly when wdata[i] is 1. Every enabled lane gets the colour register as data and (byte-mask expansion AND mask register) as its bit enable. Disabled lanes get zero enable and zero data. col_base equals col_addr with bits 2:0 cleared.
- R7: ld_mask high at a clock edge loads wdata into the mask register. A command in the same cycle still uses the previous mask. The value is kept until the next load.
- R8: ld_color high at a clock edge loads wdata into the colour register. A block write in the same cycle still uses the previous colour. The value is kept until the next load.
- R9: A read command (cmd = 2'b01) sets rd_oe to the inverse of byte_mask and enables no lane.
- R10: A no-op command (cmd = 2'b00) gives zero lane enables, zero bit enables, zero data, zero col_base and zero rd_oe.
- R11: Every output reflects the command sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | 00 no-op, 01 read, 10 write, 11 block write |
| sf_flag | input | 1 | Special-function flag; high enables graphics masking |
| byte_mask | input | 4 | Per-byte mask, bit k covers data bits 8k+7:8k |
| col_addr | input | 8 | Column address |
| wdata | input | 32 | Write data, register load value, block column select in bits 7:0 |
| ld_mask | input | 1 | Load strobe for the per-bit mask register |
| ld_color | input | 1 | Load strobe for the colour register |
| col_we | output | 8 | Lane write enables |
| col_base | output | 8 | Aligned column group address |
| col_bit_en | output | 256 | Bit enables, lane i at bits 32i+31:32i |
| col_data | output | 256 | Write data, lane i at bits 32i+31:32i |
| rd_oe | output | 4 | Per-byte read output enable |

## Verification
The assertions assume that the command, flag, mask and load inputs are held stable around each rising edge, and that reset lasts at least one edge, so that every past value they refer to was sampled by the design. They make no assumption about when loads happen relative to commands, since the same-cycle ordering is part of the behaviour. The stimulus changes inputs only on falling edges. It holds reset for several cycles with a no-op command. It includes a load that coincides with a write, to cover the old-value case.

// File: rtl/gwm_pkg.sv
package gwm_pkg;
  typedef enum logic [1:0] {
    GWM_NOP  = 2'b00,
    GWM_READ = 2'b01,
    GWM_WR   = 2'b10,
    GWM_BLK  = 2'b11
  } gwm_cmd_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic blk;
    logic pbm;
  } gwm_mode_t;
endpackage

// File: rtl/gwm_decode.sv
module gwm_decode
  import gwm_pkg::*;
(
  input  logic [1:0] cmd,
  input  logic       sf_flag,
  output gwm_mode_t  mode
);
  gwm_cmd_e c;
  always_comb begin
    c         = gwm_cmd_e'(cmd);
    mode.rd   = (c == GWM_READ);
    mode.wr   = (c == GWM_WR) || (c == GWM_BLK);
    mode.blk  = (c == GWM_BLK) && sf_flag;
    mode.pbm  = mode.wr && sf_flag;
  end
endmodule

// File: rtl/gwm_regs.sv
module gwm_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mask,
  input  logic              ld_color,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] color_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      color_q <= '0;
    end else begin
      if (ld_mask)  mask_q  <= din;
      if (ld_color) color_q <= din;
    end
  end
endmodule

// File: rtl/gwm_lane.sv
module gwm_lane #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int IDX    = 0
) (
  input  logic              is_wr,
  input  logic              is_blk,
  input  logic              blk_bit,
  input  logic [SEL_W-1:0]  col_lo,
  input  logic [DATA_W-1:0] eff_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] color,
  output logic              lane_we,
  output logic [DATA_W-1:0] lane_en,
  output logic [DATA_W-1:0] lane_data
);
  function automatic logic lane_hit(input logic wr, input logic blk,
                                    input logic bbit, input logic [SEL_W-1:0] lo);
    if (blk) return bbit;
    return wr && (lo == SEL_W'(IDX));
  endfunction

  always_comb begin
    lane_we   = lane_hit(is_wr, is_blk, blk_bit, col_lo);
    lane_en   = lane_we ? eff_en : '0;
    lane_data = lane_we ? (is_blk ? color : wr_data) : '0;
  end
endmodule

// File: rtl/gfx_wmask_unit.sv
module gfx_wmask_unit
  import gwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCOL   = 8,
  parameter int COL_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cmd,
  input  logic                     sf_flag,
  input  logic [DATA_W/8-1:0]      byte_mask,
  input  logic [COL_AW-1:0]        col_addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     ld_mask,
  input  logic                     ld_color,
  output logic [NCOL-1:0]          col_we,
  output logic [COL_AW-1:0]        col_base,
  output logic [NCOL*DATA_W-1:0]   col_bit_en,
  output logic [NCOL*DATA_W-1:0]   col_data,
  output logic [DATA_W/8-1:0]      rd_oe
);
  localparam int NBYTE = DATA_W / 8;
  localparam int SEL_W = $clog2(NCOL);

  function automatic logic [DATA_W-1:0] spread_bytes(input logic [NBYTE-1:0] keep);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < NBYTE; b++) r[b*8 +: 8] = {8{keep[b]}};
    return r;
  endfunction

  function automatic logic [COL_AW-1:0] align_col(input logic [COL_AW-1:0] a);
    return a & ~COL_AW'(NCOL - 1);
  endfunction

  gwm_mode_t         mode;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] color_q;
  logic [DATA_W-1:0] byte_en;
  logic [DATA_W-1:0] eff_en;
  logic [NCOL-1:0]   lane_we;
  logic [NCOL*DATA_W-1:0] lane_en;
  logic [NCOL*DATA_W-1:0] lane_data;

  gwm_decode u_dec (.cmd(cmd), .sf_flag(sf_flag), .mode(mode));

  gwm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_mask(ld_mask), .ld_color(ld_color),
    .din(wdata), .mask_q(mask_q), .color_q(color_q)
  );

  always_comb begin
    byte_en = spread_bytes(~byte_mask);
    eff_en  = mode.pbm ? (byte_en & mask_q) : byte_en;
  end

  for (genvar i = 0; i < NCOL; i++) begin : g_lane
    gwm_lane #(.DATA_W(DATA_W), .SEL_W(SEL_W), .IDX(i)) u_lane (
      .is_wr    (mode.wr),
      .is_blk   (mode.blk),
      .blk_bit  (wdata[i]),
      .col_lo   (col_addr[SEL_W-1:0]),
      .eff_en   (eff_en),
      .wr_data  (wdata),
      .color    (color_q),
      .lane_we  (lane_we[i]),
      .lane_en  (lane_en[i*DATA_W +: DATA_W]),
      .lane_data(lane_data[i*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_we     <= '0;
      col_base   <= '0;
      col_bit_en <= '0;
      col_data   <= '0;
      rd_oe      <= '0;
    end else begin
      col_we     <= lane_we;
      col_base   <= mode.wr ? align_col(col_addr) : '0;
      col_bit_en <= lane_en;
      col_data   <= lane_data;
      rd_oe      <= mode.rd ? ~byte_mask : '0;
    end
  end
endmodule

// File: rtl/gfx_wmask_unit_chk.sv
module gfx_wmask_unit_chk #(
  parameter int DATA_W = 32,
  parameter int NCOL   = 8,
  parameter int COL_AW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             cmd,
  input logic                   sf_flag,
  input logic [DATA_W/8-1:0]    byte_mask,
  input logic [COL_AW-1:0]      col_addr,
  input logic [DATA_W-1:0]      wdata,
  input logic                   ld_mask,
  input logic                   ld_color,
  input logic [NCOL-1:0]        col_we,
  input logic [COL_AW-1:0]      col_base,
  input logic [NCOL*DATA_W-1:0] col_bit_en,
  input logic [NCOL*DATA_W-1:0] col_data,
  input logic [DATA_W/8-1:0]    rd_oe,
  input logic [DATA_W-1:0]      mask_q,
  input logic [DATA_W-1:0]      color_q
);
  localparam int NBYTE = DATA_W / 8;
  logic [DATA_W-1:0] any_en;
  always_comb begin
    any_en = '0;
    for (int i = 0; i < NCOL; i++) any_en |= col_bit_en[i*DATA_W +: DATA_W];
  end

  a_r9_read_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd) == 2'b01 |-> col_we == '0);
  a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe != '0 |-> $past(cmd) == 2'b01);
  a_r10_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd) == 2'b00 |-> (col_we == '0 && col_data == '0 && rd_oe == '0));
  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd) == 2'b10 && !$past(sf_flag)) |-> $countones(col_we) == 1);
  a_r6_block_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd) == 2'b11 && $past(sf_flag)) |-> col_we == $past(wdata[NCOL-1:0]));
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_mask) |-> $stable(mask_q));
  a_r8_color_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_color) |-> $stable(color_q));
  a_r11_no_en_without_we: assert property (@(posedge clk) disable iff (!rst_n)
    col_we == '0 |-> any_en == '0);

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    a_r2_byte_off: assert property (@(posedge clk) disable iff (!rst_n)
      $past(byte_mask[k]) |-> any_en[k*8 +: 8] == 8'h00);
  end
endmodule

bind gfx_wmask_unit gfx_wmask_unit_chk #(.DATA_W(DATA_W), .NCOL(NCOL), .COL_AW(COL_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .sf_flag(sf_flag), .byte_mask(byte_mask),
  .col_addr(col_addr), .wdata(wdata), .ld_mask(ld_mask), .ld_color(ld_color),
  .col_we(col_we), .col_base(col_base), .col_bit_en(col_bit_en), .col_data(col_data),
  .rd_oe(rd_oe), .mask_q(mask_q), .color_q(color_q)
);

// File: tb/gfx_wmask_unit_bench.sv
module gfx_wmask_unit_bench;
  localparam int DW = 32;
  localparam int NC = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic sf_flag = 1'b0;
  logic [3:0] byte_mask = 4'h0;
  logic [AW-1:0] col_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ld_mask = 1'b0, ld_color = 1'b0;
  logic [NC-1:0] col_we;
  logic [AW-1:0] col_base;
  logic [NC*DW-1:0] col_bit_en, col_data;
  logic [3:0] rd_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gfx_wmask_unit u_gfx_wmask_unit (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sf_flag(sf_flag), .byte_mask(byte_mask),
    .col_addr(col_addr), .wdata(wdata), .ld_mask(ld_mask), .ld_color(ld_color),
    .col_we(col_we), .col_base(col_base), .col_bit_en(col_bit_en),
    .col_data(col_data), .rd_oe(rd_oe)
  );

  function automatic logic [31:0] keep_word(input logic [3:0] bm);
    logic [31:0] w = 32'h0;
    for (int k = 0; k < 4; k++) if (!bm[k]) w = w | (32'hFF << (8 * k));
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic sf, input logic [3:0] bm,
                       input logic [7:0] ca, input logic [31:0] d,
                       input logic lm, input logic lc);
    @(negedge clk);
    cmd = c; sf_flag = sf; byte_mask = bm; col_addr = ca; wdata = d;
    ld_mask = lm; ld_color = lc;
    @(posedge clk); #1;
    @(negedge clk);
    cmd = 2'b00; ld_mask = 0; ld_color = 0;
  endtask

  // compares every lane against a model of which lanes are on
  task automatic expect_lanes(input string req, input logic [7:0] we, input logic [7:0] base,
                              input logic [31:0] en, input logic [31:0] dat);
    logic [255:0] e_en = '0, e_dat = '0;
    for (int i = 0; i < NC; i++) if (we[i]) begin
      e_en[i*32 +: 32] = en;
      e_dat[i*32 +: 32] = dat;
    end
    chk(req, "col_we", 256'(col_we), 256'(we));
    chk(req, "col_base", 256'(col_base), 256'(base));
    chk(req, "bit_en", col_bit_en, e_en);
    chk(req, "data", col_data, e_dat);
  endtask

  task automatic t_reset;
    chk("R1", "we", 256'(col_we), 0);
    chk("R1", "oe", 256'(rd_oe), 0);
    chk("R1", "bit_en", col_bit_en, 0);
    issue(2'b10, 1, 4'h0, 8'h05, 32'h1234_5678, 0, 0);
    expect_lanes("R1 R5", 8'h20, 8'h00, 32'hFFFF_FFFF, 32'h1234_5678);
    issue(2'b11, 1, 4'h0, 8'h10, 32'h0000_0081, 0, 0);
    expect_lanes("R1 R6", 8'h81, 8'h10, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_plain;
    issue(2'b10, 0, 4'b0101, 8'h2B, 32'hA5A5_5A5A, 0, 0);
    expect_lanes("R2 R3 R11", 8'h08, 8'h28, 32'hFF00_FF00, 32'hA5A5_5A5A);
    issue(2'b11, 0, 4'b1000, 8'hF0, 32'h0BAD_00FF, 0, 0);
    expect_lanes("R4", 8'h01, 8'hF0, 32'h00FF_FFFF, 32'h0BAD_00FF);
  endtask

  task automatic t_mask;
    issue(2'b10, 1, 4'h0, 8'h01, 32'h0F0F_0F0F, 1, 0);
    expect_lanes("R7 old", 8'h02, 8'h00, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
    issue(2'b10, 1, 4'b1000, 8'h07, 32'hFFFF_FFFF, 0, 0);
    expect_lanes("R5 R7", 8'h80, 8'h00, 32'h000F_0F0F, 32'hFFFF_FFFF);
    issue(2'b10, 0, 4'b0000, 8'h07, 32'h1111_2222, 0, 0);
    expect_lanes("R3 mask ignored", 8'h80, 8'h00, 32'hFFFF_FFFF, 32'h1111_2222);
  endtask

  task automatic t_block;
    issue(2'b11, 1, 4'h0, 8'h40, 32'hCAFE_F0FF, 0, 1);
    expect_lanes("R8 old", 8'hFF, 8'h40, 32'h0F0F_0F0F, 32'h0);
    issue(2'b11, 1, 4'b0010, 8'h47, 32'h0000_00A6, 0, 0);
    expect_lanes("R6 R8", 8'hA6, 8'h40, 32'h0F0F_000F, 32'hCAFE_F0FF);
    issue(2'b00, 1, 4'h0, 8'h47, 32'hFFFF_FFFF, 0, 0);
    expect_lanes("R10", 8'h00, 8'h00, 32'h0, 32'h0);
    chk("R10", "oe", 256'(rd_oe), 0);
  endtask

  task automatic t_read;
    issue(2'b01, 1, 4'b1001, 8'h33, 32'hFFFF_FFFF, 0, 0);
    chk("R9", "oe", 256'(rd_oe), 256'(4'b0110));
    chk("R9", "we", 256'(col_we), 0);
    @(posedge clk); #1;
    chk("R10", "oe after", 256'(rd_oe), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset_pre: begin
      chk("R1", "we in reset", 256'(col_we), 0);
    end
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_plain;
    t_mask;
    t_block;
    t_read;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule